// File: doc/BRIEF.md
# DAC Sample FIFO with Swing Replay

This block sits between the register interface that produces converter sample words and the converter itself. It holds up to `DEPTH` 12-bit samples and hands one to the converter each time a trigger arrives. The trigger comes either from a hardware trigger line or from a software trigger pulse. A two-bit mode input chooses between three behaviours. In bypass, a single holding word goes straight to the converter. In normal mode, the samples are played once in order. In swing mode, a full buffer of samples is replayed forward and then backward, over and over, without software rewriting it.

The occupancy count is the number of accepted writes, minus forward read-pointer moves, plus backward read-pointer moves. It is cleared by reset or by the pointer-reset input. The read pointer always indexes the word currently on the converter output. A forward move therefore presents the entry at read pointer + 1, and a backward move presents the entry at read pointer − 1. Both pointers wrap modulo `DEPTH`.

The status outputs follow the occupancy. The full, nearly-empty and watermark outputs are levels. Overflow and underflow are one-cycle pulses that appear in the cycle after the offending request.

Top module: `dac_swing_fifo`

## Requirements
- R1: When mode is 0 or 3 (bypass), a write places `wr_data` on `dac_data` in the next cycle, with a one-cycle `dac_upd` pulse. In bypass, both pointers and the occupancy stay unchanged, and triggers have no effect.
- R2: When mode is 1 (normal) and the FIFO is not full, a write stores the word at `wr_ptr`. `wr_ptr` then advances by one, modulo `DEPTH`, in the next cycle.
- R3: In normal mode, a trigger with occupancy of at least 2 advances `rd_ptr` by one in the next cycle. In that same cycle, `dac_data` shows the entry at the new `rd_ptr`.
- R4: The effective trigger is `sw_trig` when `trig_sel` is 1 and `hw_trig` when `trig_sel` is 0. It only counts while `en` is 1. The source that is not selected has no effect.
- R5: `full` is 1 exactly when the occupancy equals `DEPTH`. In normal mode, a write while full is dropped and raises `ovf` for one cycle.
- R6: `nempty` is 1 exactly when the occupancy is 1. In normal mode, a trigger with occupancy below 2 raises `udf` for one cycle and leaves `rd_ptr` unchanged.
- R7: `wm` is 1 exactly when the occupancy is below `wm_level`, where `wm_level` ranges from 0 to `DEPTH`.
- R8: Mode 2 (swing) never raises `ovf` or `udf`. In swing mode, a write is stored only when the FIFO is not full and no trigger occurs in that cycle. Any other write is dropped silently.
- R9: In swing mode, starting from full, triggers step `rd_ptr` forward until the occupancy is 1. Further triggers step it backward until the occupancy is `DEPTH` again, and the cycle repeats. A held direction bit flips at each end. Every step presents the newly indexed entry.
- R10: `ptr_rst` clears both pointers, the occupancy and the direction bit in the next cycle. It overrides any write or trigger in the same cycle and leaves `dac_data` as it was.
- R11: `dac_upd` is 1 for exactly one cycle each time `dac_data` is loaded, and is 0 otherwise.
- R12: After reset, `dac_data`, both pointers, `dac_upd`, `ovf`, `udf`, `full` and `nempty` are 0. `wm` equals (`wm_level` > 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Trigger enable |
| mode | input | 2 | 0/3 bypass, 1 normal, 2 swing |
| trig_sel | input | 1 | 1 selects software trigger, 0 hardware trigger |
| hw_trig | input | 1 | Hardware trigger, one per cycle high |
| sw_trig | input | 1 | Software trigger pulse |
| wr_en | input | 1 | Sample write strobe |
| wr_data | input | DW | Sample word to write |
| wm_level | input | AW+1 | Watermark threshold, 0..DEPTH |
| ptr_rst | input | 1 | Clear pointers and occupancy |
| dac_data | output | DW | Word presented to the converter |
| dac_upd | output | 1 | Pulse when dac_data is loaded |
| rd_ptr | output | AW | Read pointer |
| wr_ptr | output | AW | Write pointer |
| ovf | output | 1 | Overflow pulse |
| udf | output | 1 | Underflow pulse |
| wm | output | 1 | Occupancy below watermark |
| nempty | output | 1 | Occupancy equals 1 |
| full | output | 1 | Occupancy equals DEPTH |

## Verification
The directed tests cover several distinct cases:
- A fill-to-overflow run and a drain-to-underflow run, which separate an off-by-one in the full test from one in the nearly-empty test.
- A complete swing round trip of an eight-deep buffer, which shows whether the direction flips exactly at occupancy 1 and at full, and whether backward steps read the right entries.
- Trigger tests with `en` low and with the unselected source active, which isolate the gating logic from the FIFO itself.

Long random runs then mix writes, triggers, mode switches and pointer resets. These mixed runs catch interactions the directed cases do not, such as a write landing in the same cycle as a forward or backward step, or a switch into swing mode with a stale direction bit.

// File: rtl/dac_swing_fifo.sv
module dac_swing_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 12,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [1:0]    mode,
  input  logic          trig_sel,
  input  logic          hw_trig,
  input  logic          sw_trig,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic [AW:0]   wm_level,
  input  logic          ptr_rst,
  output logic [DW-1:0] dac_data,
  output logic          dac_upd,
  output logic [AW-1:0] rd_ptr,
  output logic [AW-1:0] wr_ptr,
  output logic          ovf,
  output logic          udf,
  output logic          wm,
  output logic          nempty,
  output logic          full
);

  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] cnt;
  logic          dir;

  wire trig   = en & (trig_sel ? sw_trig : hw_trig);
  wire normal = (mode == 2'd1);
  wire swing  = (mode == 2'd2);
  wire bypass = !normal && !swing;

  wire is_full = (cnt == CW'(DEPTH));
  wire two_up  = (cnt >= CW'(2));
  wire edir    = is_full ? 1'b0 : (two_up ? dir : 1'b1);

  wire [AW-1:0] rd_nx = rd_ptr + 1'b1;
  wire [AW-1:0] rd_pv = rd_ptr - 1'b1;

  wire fwd_ok = trig && two_up && (normal || (swing && !edir));
  wire bwd_ok = trig && swing && edir && !is_full && (cnt != '0);
  wire do_wr  = wr_en && !is_full && (normal || (swing && !trig));

  assign full   = is_full;
  assign nempty = (cnt == CW'(1));
  assign wm     = (cnt < wm_level);

  always_ff @(posedge clk)
    if (rst_n && !ptr_rst && do_wr) mem[wr_ptr] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dac_data <= '0;
      dac_upd  <= 1'b0;
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      cnt      <= '0;
      dir      <= 1'b0;
      ovf      <= 1'b0;
      udf      <= 1'b0;
    end else if (ptr_rst) begin
      dac_upd <= 1'b0;
      rd_ptr  <= '0;
      wr_ptr  <= '0;
      cnt     <= '0;
      dir     <= 1'b0;
      ovf     <= 1'b0;
      udf     <= 1'b0;
    end else begin
      ovf     <= normal && wr_en && is_full;
      udf     <= normal && trig && !two_up;
      dac_upd <= (bypass && wr_en) || fwd_ok || bwd_ok;
      if (bypass && wr_en) dac_data <= wr_data;
      if (do_wr) wr_ptr <= wr_ptr + 1'b1;
      if (fwd_ok) begin
        rd_ptr   <= rd_nx;
        dac_data <= mem[rd_nx];
        if (swing) dir <= (cnt == CW'(2));
      end
      if (bwd_ok) begin
        rd_ptr   <= rd_pv;
        dac_data <= mem[rd_pv];
        dir      <= (cnt != CW'(DEPTH - 1));
      end
      cnt <= cnt + CW'(do_wr) + CW'(bwd_ok) - CW'(fwd_ok);
    end
  end

  p_bypass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && wr_en && !ptr_rst) |=> (dac_upd && dac_data == $past(wr_data) && $stable(wr_ptr) && $stable(rd_ptr)));

  p_wr_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (normal && wr_en && !full && !ptr_rst) |=> (wr_ptr == AW'($past(wr_ptr) + 1'b1)));

  p_trig_adv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (normal && trig && !full && !nempty && cnt != '0 && !ptr_rst) |=> (rd_ptr == AW'($past(rd_ptr) + 1'b1) && dac_upd));

  p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !bypass && !ptr_rst) |=> ($stable(rd_ptr) && !dac_upd));

  p_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (normal && wr_en && full && !ptr_rst) |=> (ovf && $stable(wr_ptr)));

  p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && nempty));

  p_udf_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (normal && trig && nempty && !ptr_rst) |=> (udf && $stable(rd_ptr)));

  p_swing_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (swing && !ptr_rst) |=> (!ovf && !udf));

  p_swing_fwd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (swing && trig && full && !ptr_rst) |=> (rd_ptr == AW'($past(rd_ptr) + 1'b1) && !full));

  p_ptr_rst_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_rst |=> (rd_ptr == '0 && wr_ptr == '0 && !full && !nempty && $stable(dac_data)));

endmodule

// File: tb/dac_swing_fifo_test.sv
`timescale 1ns/1ps
module dac_swing_fifo_test;
  localparam int D  = 8;
  localparam int DW = 12;
  localparam int AW = $clog2(D);

  logic clk = 0, rst_n = 0;
  logic en = 1, trig_sel = 0, hw_trig = 0, sw_trig = 0, wr_en = 0, ptr_rst = 0;
  logic [1:0] mode = 0;
  logic [DW-1:0] wr_data = 0;
  logic [AW:0] wm_level = 0;
  logic [DW-1:0] dac_data;
  logic dac_upd, ovf, udf, wm, nempty, full;
  logic [AW-1:0] rd_ptr, wr_ptr;

  int n_chk = 0, n_bad = 0;

  int m_mem [D];
  int m_rd, m_wr, m_cnt, m_dir, e_data, e_upd, e_ovf, e_udf;

  always #5 clk = ~clk;

  dac_swing_fifo #(.DEPTH(D), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .trig_sel(trig_sel),
    .hw_trig(hw_trig), .sw_trig(sw_trig), .wr_en(wr_en), .wr_data(wr_data),
    .wm_level(wm_level), .ptr_rst(ptr_rst), .dac_data(dac_data), .dac_upd(dac_upd),
    .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .ovf(ovf), .udf(udf), .wm(wm),
    .nempty(nempty), .full(full));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int f_wm(input int cnt, input int lvl);
    return (cnt < lvl) ? 1 : 0;
  endfunction

  function automatic int f_eff_trig(input logic e, input logic sel, input logic h, input logic s);
    return (e && (sel ? s : h)) ? 1 : 0;
  endfunction

  task automatic model_clear();
    m_rd = 0; m_wr = 0; m_cnt = 0; m_dir = 0;
  endtask

  task automatic model_step(input int w, input int wd, input int trg, input int pr);
    int fa, ba, wa, isf, edir;
    e_upd = 0; e_ovf = 0; e_udf = 0;
    isf = (m_cnt == D);
    if (pr != 0) model_clear();
    else if (mode == 2'd1) begin
      e_ovf = (w != 0 && isf != 0) ? 1 : 0;
      e_udf = (trg != 0 && m_cnt < 2) ? 1 : 0;
      fa = (trg != 0 && m_cnt >= 2) ? 1 : 0;
      wa = (w != 0 && isf == 0) ? 1 : 0;
      if (fa != 0) begin m_rd = (m_rd + 1) % D; e_data = m_mem[m_rd]; e_upd = 1; end
      if (wa != 0) begin m_mem[m_wr] = wd; m_wr = (m_wr + 1) % D; end
      m_cnt = m_cnt + wa - fa;
    end else if (mode == 2'd2) begin
      edir = (isf != 0) ? 0 : ((m_cnt <= 1) ? 1 : m_dir);
      fa = (trg != 0 && edir == 0 && m_cnt >= 2) ? 1 : 0;
      ba = (trg != 0 && edir == 1 && isf == 0 && m_cnt != 0) ? 1 : 0;
      wa = (w != 0 && isf == 0 && trg == 0) ? 1 : 0;
      if (fa != 0) begin
        m_rd = (m_rd + 1) % D; e_data = m_mem[m_rd]; e_upd = 1;
        m_dir = (m_cnt == 2) ? 1 : 0;
      end
      if (ba != 0) begin
        m_rd = (m_rd + D - 1) % D; e_data = m_mem[m_rd]; e_upd = 1;
        m_dir = (m_cnt != D - 1) ? 1 : 0;
      end
      if (wa != 0) begin m_mem[m_wr] = wd; m_wr = (m_wr + 1) % D; end
      m_cnt = m_cnt + wa - fa + ba;
    end else if (w != 0) begin
      e_data = wd; e_upd = 1;
    end
  endtask

  task automatic cyc(input logic w, input int wd, input logic h, input logic s, input logic pr);
    string dtag;
    @(negedge clk);
    wr_en = w; wr_data = DW'(wd); hw_trig = h; sw_trig = s; ptr_rst = pr;
    model_step(w, wd & 12'hfff, f_eff_trig(en, trig_sel, h, s), pr);
    @(posedge clk); #1;
    dtag = (mode == 2'd2) ? "R9 dac_data" : ((mode == 2'd1) ? "R3 dac_data" : "R1 dac_data");
    chk(dtag, dac_data, e_data);
    chk("R11 dac_upd", dac_upd, e_upd);
    chk("R3 rd_ptr", rd_ptr, m_rd);
    chk("R2 wr_ptr", wr_ptr, m_wr);
    chk("R5 ovf", ovf, e_ovf);
    chk("R6 udf", udf, e_udf);
    chk("R5 full", full, (m_cnt == D) ? 1 : 0);
    chk("R6 nempty", nempty, (m_cnt == 1) ? 1 : 0);
    chk("R7 wm", wm, f_wm(m_cnt, wm_level));
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    foreach (m_mem[i]) m_mem[i] = 0;
    model_clear(); e_data = 0;
    wm_level = 4'd3;
    repeat (3) @(posedge clk);
    #1;
    // R12 reset state
    chk("R12 dac_data", dac_data, 0);
    chk("R12 rd_ptr", rd_ptr, 0);
    chk("R12 full", full, 0);
    chk("R12 wm", wm, 1);
    @(negedge clk); rst_n = 1;

    // R1 bypass
    mode = 2'd0;
    cyc(1, 12'h5a5, 0, 0, 0);
    chk("R1 bypass data", dac_data, 12'h5a5);
    cyc(0, 0, 1, 1, 0);
    chk("R1 trig ignored", dac_upd, 0);
    mode = 2'd3;
    cyc(1, 12'h0f1, 0, 0, 0);
    chk("R1 mode3 bypass", dac_data, 12'h0f1);

    // R2/R5 fill and overflow
    mode = 2'd1; wm_level = 4'd8;
    for (int i = 0; i < D; i++) cyc(1, 100 + i, 0, 0, 0);
    chk("R5 full after fill", full, 1);
    chk("R7 wm at full lvl D", wm, 0);
    cyc(1, 999, 0, 0, 0);
    chk("R5 ovf pulse", ovf, 1);
    cyc(0, 0, 0, 0, 0);
    chk("R5 ovf one cycle", ovf, 0);

    // R4 gating and source select
    en = 0;
    cyc(0, 0, 1, 1, 0);
    chk("R4 en low ignores", rd_ptr, 0);
    en = 1; trig_sel = 1;
    cyc(0, 0, 1, 0, 0);
    chk("R4 hw ignored when sw selected", dac_upd, 0);
    cyc(0, 0, 0, 1, 0);
    chk("R4 sw trigger data", dac_data, 101);
    trig_sel = 0;
    cyc(0, 0, 0, 1, 0);
    chk("R4 sw ignored when hw selected", dac_upd, 0);

    // R6 drain to underflow
    for (int i = 0; i < D - 2; i++) cyc(0, 0, 1, 0, 0);
    chk("R6 nempty", nempty, 1);
    chk("R3 last data", dac_data, 107);
    cyc(0, 0, 1, 0, 0);
    chk("R6 udf", udf, 1);
    chk("R6 rd held", rd_ptr, 7);

    // R10 pointer reset
    cyc(1, 1, 1, 0, 1);
    chk("R10 rd_ptr", rd_ptr, 0);
    chk("R10 dac_data kept", dac_data, 107);

    // R8/R9 swing round trip
    for (int i = 0; i < D; i++) cyc(1, 200 + i, 0, 0, 0);
    mode = 2'd2;
    cyc(1, 7, 0, 0, 0);
    chk("R8 no ovf in swing", ovf, 0);
    for (int i = 0; i < D - 1; i++) cyc(0, 0, 1, 0, 0);
    chk("R9 forward end data", dac_data, 207);
    chk("R9 forward end nempty", nempty, 1);
    cyc(0, 0, 1, 0, 0);
    chk("R9 first backward", dac_data, 206);
    chk("R8 no udf in swing", udf, 0);
    for (int i = 0; i < D - 2; i++) cyc(0, 0, 1, 0, 0);
    chk("R9 backward end data", dac_data, 200);
    chk("R9 backward end full", full, 1);
    cyc(0, 0, 1, 0, 0);
    chk("R9 bounce forward", dac_data, 201);

    // random mix
    for (int i = 0; i < 6000; i++) begin
      if (i % 150 == 0) begin
        int r;
        r = $urandom_range(0, 9);
        mode = (r < 4) ? 2'd1 : ((r < 8) ? 2'd2 : 2'($urandom_range(0, 3)));
        trig_sel = 1'($urandom_range(0, 1));
        wm_level = (AW + 1)'($urandom_range(0, D));
      end
      en = ($urandom_range(0, 9) != 0);
      cyc(1'($urandom_range(0, 1)), int'($urandom_range(0, 4095)),
          1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
          ($urandom_range(0, 199) == 0));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule